// File: doc/BRIEF.md
# Quadrature-Capable Pulse Counter

This block counts pulses arriving on two sampled input lines, `s0_in` and `s1_in`, under one of four operating modes: off, single input checked only on a sampling strobe, single input checked on every clock, and two-phase quadrature decode. A main counter wraps at a programmable limit and raises sticky overflow and underflow flags when it does. An auxiliary counter runs from the same pulses through its own event filter and wraps at its full width. A sticky flag records each reversal of counting direction.

Software reaches the block through a plain register port: a one-cycle write strobe with address and data, and a combinational read mux. The limit is normally changed through a buffer register. In the two clock-driven modes the buffered value moves into the live limit only after three counting pulses, so that it changes in step with the count. Writing the count or the limit directly holds counting off for that one cycle. The mode setting is not touched by such a write. The two inputs are expected to be synchronous to `clk` already. There is no streaming data path, so there is no valid/ready handshake.

Top module: `pulse_counter`

## Requirements
- R1: After reset the count and auxiliary count are 0, the live limit and the limit buffer are all ones, all flags are 0, and the control register reads 0x1A0. Its fields are mode[1:0], fall[2], dir_s1[3], sw_down[4], main_ev[6:5] and aux_ev[8:7].
- R2: With mode 0 (off), input activity changes neither counter.
- R3: In mode 2 each active edge of `s0_in` is a pulse. The active edge is rising when fall=0 and falling when fall=1. The pulse counts down when the selected direction source is 1. That source is `s1_in` when dir_s1=1 and sw_down when dir_s1=0.
- R4: In mode 1, `s0_in` is only looked at in cycles where `smp_tick` is high. A pulse occurs when the strobed value differs from the previous strobed value and is at the active level. Direction is chosen as in R3.
- R5: In mode 3 the input pair maps to a position as {s1,s0}: 00 is 0, 01 is 1, 11 is 2 and 10 is 3. A position step of +1 (mod 4) counts up, a step of -1 counts down, and a step of 2 or 0 is ignored.
- R6: Each counter has an event selector: 0 counts both ways, 1 counts only up pulses, 2 counts only down pulses, and 3 never counts.
- R7: The auxiliary counter follows its own selector, independently of the main one, and wraps modulo 2^CNT_W.
- R8: An up count at the limit gives 0 and sets the overflow flag. A down count at 0 gives the limit and sets the underflow flag.
- R9: The direction-change flag is set by any pulse whose direction differs from the previous pulse's direction. The direction before the first pulse counts as up.
- R10: A write to the limit buffer (address 3) reaches the live limit (address 4) one cycle later in modes 0 and 1. In modes 2 and 3 it arrives on the third pulse after the write, and that third pulse still counts against the old limit.
- R11: A write to the count (address 1) or to the live limit (address 4) discards any pulse in that cycle. The written value is used as is, and the mode is unchanged.
- R12: The flags read at address 5 as bit0 overflow, bit1 underflow and bit2 direction change. They stay set until a 1 is written to that bit at address 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_in | input | 1 | Count input / phase A |
| s1_in | input | 1 | Direction input / phase B |
| smp_tick | input | 1 | Sampling strobe for mode 1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 ctrl, 1 count, 2 aux, 3 limit buffer, 4 limit, 5 flags) |
| wr_data | input | BUS_W | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | BUS_W | Read data, combinational |
| count_o | output | CNT_W | Main count |
| aux_o | output | CNT_W | Auxiliary count |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| dirchg_o | output | 1 | Sticky direction-change flag |

## Verification
The edge and phase history registers are the most likely to hold a wrong value. If one does, it shows on `count_o` on the very next input change, as a missed, doubled or reversed step. A limit register that loads at the wrong time only shows up when the count wraps, so the bench sweeps wraps in both directions for both limit paths and reads the live limit after each counting pulse. A flag that clears itself or is set wrongly shows at the flag outputs within one cycle.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;
  localparam int PC_AW = 3;
  typedef logic [PC_AW-1:0] pc_addr_t;

  localparam pc_addr_t A_CTRL = 3'd0;
  localparam pc_addr_t A_CNT  = 3'd1;
  localparam pc_addr_t A_AUX  = 3'd2;
  localparam pc_addr_t A_TOPB = 3'd3;
  localparam pc_addr_t A_TOP  = 3'd4;
  localparam pc_addr_t A_FLG  = 3'd5;

  typedef enum logic [1:0] {MD_OFF = 2'd0, MD_OVS = 2'd1, MD_EXT = 2'd2, MD_QUAD = 2'd3} pc_mode_e;
  typedef enum logic [1:0] {EV_BOTH = 2'd0, EV_UP = 2'd1, EV_DOWN = 2'd2, EV_NONE = 2'd3} pc_ev_e;

  typedef struct packed {
    pc_ev_e   aux_ev;
    pc_ev_e   main_ev;
    logic     sw_down;
    logic     dir_s1;
    logic     fall;
    pc_mode_e mode;
  } pc_ctrl_t;

  localparam int CTRL_W = $bits(pc_ctrl_t);

  function automatic logic ev_up(pc_ev_e e);
    return (e == EV_BOTH) || (e == EV_UP);
  endfunction

  function automatic logic ev_dn(pc_ev_e e);
    return (e == EV_BOTH) || (e == EV_DOWN);
  endfunction
endpackage

// File: rtl/pc_pulse_gen.sv
module pc_pulse_gen
  import pcnt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     s0,
  input  logic     s1,
  input  logic     smp_tick,
  input  pc_ctrl_t ctrl,
  output logic     pulse,
  output logic     dir
);
  logic       s0_q, s1_q, ovs_q;
  logic       lvl_ok, single_dir;
  logic [1:0] q_now, q_old, q_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q  <= 1'b0;
      s1_q  <= 1'b0;
      ovs_q <= 1'b0;
    end else begin
      s0_q <= s0;
      s1_q <= s1;
      if (smp_tick) ovs_q <= s0;
    end
  end

  // position along the two-phase cycle: {s1, s0^s1}
  assign q_now  = {s1, s0 ^ s1};
  assign q_old  = {s1_q, s0_q ^ s1_q};
  assign q_step = q_now - q_old;

  assign lvl_ok     = ctrl.fall ? ~s0 : s0;
  assign single_dir = ctrl.dir_s1 ? s1 : ctrl.sw_down;

  always_comb begin
    pulse = 1'b0;
    dir   = single_dir;
    unique case (ctrl.mode)
      MD_OFF:  pulse = 1'b0;
      MD_OVS:  pulse = smp_tick && (s0 != ovs_q) && lvl_ok;
      MD_EXT:  pulse = (s0 != s0_q) && lvl_ok;
      MD_QUAD: begin
        pulse = (q_step == 2'd1) || (q_step == 2'd3);
        dir   = (q_step == 2'd3);
      end
      default: pulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_wrap_counter.sv
module pc_wrap_counter #(
  parameter int W       = 16,
  parameter bit USE_TOP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  input  logic         dec,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         wrap_up,
  output logic         wrap_dn
);
  logic [W-1:0] lim;

  generate
    if (USE_TOP) begin : g_top
      assign lim = top;
    end else begin : g_full
      logic [W-1:0] top_unused;
      assign top_unused = top;
      assign lim = '1;
    end
  endgenerate

  assign wrap_up = !ld && inc && (cnt == lim);
  assign wrap_dn = !ld && dec && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (ld)      cnt <= ld_val;
    else if (inc)     cnt <= wrap_up ? '0 : cnt + 1'b1;
    else if (dec)     cnt <= wrap_dn ? lim : cnt - 1'b1;
  end
endmodule

// File: rtl/pc_top_sync.sv
module pc_top_sync #(
  parameter int W     = 16,
  parameter int SYNC_N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_buf,
  input  logic         wr_top,
  input  logic [W-1:0] din,
  input  logic         ext_mode,
  input  logic         tick,
  output logic [W-1:0] top,
  output logic [W-1:0] topbuf
);
  localparam int TK_W = $clog2(SYNC_N + 1);
  logic            pend;
  logic [TK_W-1:0] tk;
  logic            ready;

  assign ready = !ext_mode || (tick && (tk == TK_W'(SYNC_N - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top    <= '1;
      topbuf <= '1;
      pend   <= 1'b0;
      tk     <= '0;
    end else if (wr_top) begin
      top    <= din;
      topbuf <= din;
      pend   <= 1'b0;
      tk     <= '0;
    end else begin
      if (pend && ready) begin
        top  <= topbuf;
        pend <= 1'b0;
      end else if (pend && tick) begin
        tk <= tk + 1'b1;
      end
      if (wr_buf) begin
        topbuf <= din;
        pend   <= 1'b1;
        tk     <= '0;
      end
    end
  end
endmodule

// File: rtl/pulse_counter.sv
module pulse_counter
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s0_in,
  input  logic             s1_in,
  input  logic             smp_tick,
  input  logic             wr_en,
  input  logic [PC_AW-1:0] wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [PC_AW-1:0] rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] aux_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             dirchg_o
);
  localparam pc_ctrl_t CTRL_RST = '{aux_ev: EV_NONE, main_ev: EV_UP, sw_down: 1'b0,
                                    dir_s1: 1'b0, fall: 1'b0, mode: MD_OFF};

  pc_ctrl_t   ctrl_q;
  logic       pulse, dir, pulse_ok, prev_dir;
  logic       wr_ctrl, wr_cnt, wr_aux, wr_topb, wr_top, wr_flg;
  logic       m_wu, m_wd, aux_up_unused, aux_dn_unused;
  logic [CNT_W-1:0] top_val, topbuf_val, wr_val;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == A_CNT);
  assign wr_aux  = wr_en && (wr_addr == A_AUX);
  assign wr_topb = wr_en && (wr_addr == A_TOPB);
  assign wr_top  = wr_en && (wr_addr == A_TOP);
  assign wr_flg  = wr_en && (wr_addr == A_FLG);
  assign wr_val  = wr_data[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (wr_ctrl) ctrl_q <= pc_ctrl_t'(wr_data[CTRL_W-1:0]);
  end

  pc_pulse_gen u_pgen (
    .clk(clk), .rst_n(rst_n), .s0(s0_in), .s1(s1_in), .smp_tick(smp_tick),
    .ctrl(ctrl_q), .pulse(pulse), .dir(dir)
  );

  // direct count or limit writes hold counting off for that cycle
  assign pulse_ok = pulse && !(wr_cnt || wr_top);

  pc_top_sync #(.W(CNT_W), .SYNC_N(3)) u_tsync (
    .clk(clk), .rst_n(rst_n), .wr_buf(wr_topb), .wr_top(wr_top), .din(wr_val),
    .ext_mode(ctrl_q.mode[1]), .tick(pulse_ok && ctrl_q.mode[1]),
    .top(top_val), .topbuf(topbuf_val)
  );

  pc_wrap_counter #(.W(CNT_W), .USE_TOP(1'b1)) u_main (
    .clk(clk), .rst_n(rst_n), .ld(wr_cnt), .ld_val(wr_val),
    .inc(pulse_ok && !dir && ev_up(ctrl_q.main_ev)),
    .dec(pulse_ok && dir && ev_dn(ctrl_q.main_ev)),
    .top(top_val), .cnt(count_o), .wrap_up(m_wu), .wrap_dn(m_wd)
  );

  pc_wrap_counter #(.W(CNT_W), .USE_TOP(1'b0)) u_aux (
    .clk(clk), .rst_n(rst_n), .ld(wr_aux), .ld_val(wr_val),
    .inc(pulse_ok && !dir && ev_up(ctrl_q.aux_ev)),
    .dec(pulse_ok && dir && ev_dn(ctrl_q.aux_ev)),
    .top(top_val), .cnt(aux_o), .wrap_up(aux_up_unused), .wrap_dn(aux_dn_unused)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_o    <= 1'b0;
      unf_o    <= 1'b0;
      dirchg_o <= 1'b0;
      prev_dir <= 1'b0;
    end else begin
      ovf_o    <= (ovf_o    && !(wr_flg && wr_data[0])) || m_wu;
      unf_o    <= (unf_o    && !(wr_flg && wr_data[1])) || m_wd;
      dirchg_o <= (dirchg_o && !(wr_flg && wr_data[2])) || (pulse_ok && (dir != prev_dir));
      if (pulse_ok) prev_dir <= dir;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      A_CNT:   rd_data[CNT_W-1:0]  = count_o;
      A_AUX:   rd_data[CNT_W-1:0]  = aux_o;
      A_TOPB:  rd_data[CNT_W-1:0]  = topbuf_val;
      A_TOP:   rd_data[CNT_W-1:0]  = top_val;
      A_FLG:   rd_data[2:0]        = {dirchg_o, unf_o, ovf_o};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pcnt_checker.sv
module pcnt_checker
  import pcnt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] aux_o,
  input logic [CNT_W-1:0] top_val,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             dirchg_o,
  input logic             wr_en,
  input pc_addr_t         wr_addr,
  input logic [BUS_W-1:0] wr_data,
  input pc_ctrl_t         ctrl
);
  assert_wrap_up_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> count_o == '0);

  assert_wrap_dn_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unf_o) |-> count_o == $past(top_val));

  assert_off_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == MD_OFF && !wr_en) |=> ($stable(count_o) && $stable(aux_o)));

  assert_aux_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.aux_ev == EV_NONE && !(wr_en && wr_addr == A_AUX)) |=> $stable(aux_o));

  assert_cnt_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CNT) |=> count_o == $past(wr_data[CNT_W-1:0]));

  assert_dirchg_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dirchg_o && !(wr_en && wr_addr == A_FLG)) |=> dirchg_o);
endmodule

bind pulse_counter pcnt_checker #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_o(count_o), .aux_o(aux_o), .top_val(top_val),
  .ovf_o(ovf_o), .unf_o(unf_o), .dirchg_o(dirchg_o), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .ctrl(ctrl_q)
);

// File: tb/tb_pulse_counter.sv
module tb_pulse_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int BW = 16;
  localparam int MOD = 1 << CW;

  logic clk, rst_n, s0_in, s1_in, smp_tick, wr_en;
  logic [2:0] wr_addr, rd_addr;
  logic [BW-1:0] wr_data, rd_data;
  logic [CW-1:0] count_o, aux_o;
  logic ovf_o, unf_o, dirchg_o;

  pulse_counter #(.CNT_W(CW), .BUS_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .s0_in(s0_in), .s1_in(s1_in), .smp_tick(smp_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .count_o(count_o), .aux_o(aux_o), .ovf_o(ovf_o),
    .unf_o(unf_o), .dirchg_o(dirchg_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  int m_cnt, m_aux, m_top, m_buf, m_tk, m_mode, m_fall, m_dsrc, m_swd, m_mev, m_aev;
  bit m_pend, m_ovf, m_unf, m_dc, m_pdir, m_s0, m_s1, m_ovs;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int qi(bit a, bit b);
    return (b ? 2 : 0) + ((a ^ b) ? 1 : 0);
  endfunction

  function automatic int mk_ctrl(int md, int fl, int ds, int sw, int mev, int aev);
    return md | (fl << 2) | (ds << 3) | (sw << 4) | (mev << 5) | (aev << 7);
  endfunction

  task automatic model_edge(bit a, bit b, bit t, bit sq);
    bit p = 0, d = 0;
    int st;
    case (m_mode)
      1: begin p = t && (a != m_ovs) && (m_fall ? !a : a); d = m_dsrc ? b : m_swd[0]; end
      2: begin p = (a != m_s0) && (m_fall ? !a : a);       d = m_dsrc ? b : m_swd[0]; end
      3: begin st = (qi(a, b) - qi(m_s0, m_s1) + 4) % 4; p = (st == 1) || (st == 3); d = (st == 3); end
      default: p = 0;
    endcase
    if (sq) p = 0;
    if (p) begin
      if (d != m_pdir) m_dc = 1;
      m_pdir = d;
      if (!d && (m_mev == 0 || m_mev == 1)) begin
        if (m_cnt == m_top) begin m_cnt = 0; m_ovf = 1; end else m_cnt++;
      end
      if (d && (m_mev == 0 || m_mev == 2)) begin
        if (m_cnt == 0) begin m_cnt = m_top; m_unf = 1; end else m_cnt--;
      end
      if (!d && (m_aev == 0 || m_aev == 1)) m_aux = (m_aux + 1) % MOD;
      if (d && (m_aev == 0 || m_aev == 2)) m_aux = (m_aux + MOD - 1) % MOD;
    end
    if (m_pend) begin
      if (m_mode >= 2) begin
        if (p) begin
          m_tk++;
          if (m_tk == 3) begin m_top = m_buf; m_pend = 0; end
        end
      end else begin
        m_top = m_buf; m_pend = 0;
      end
    end
    m_s0 = a; m_s1 = b;
    if (t) m_ovs = a;
  endtask

  task automatic step(bit a, bit b, bit t);
    s0_in = a; s1_in = b; smp_tick = t;
    model_edge(a, b, t, 1'b0);
    @(negedge clk);
    smp_tick = 1'b0;
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data[BW-1:0]; smp_tick = 1'b0;
    model_edge(s0_in, s1_in, 1'b0, (addr == 1) || (addr == 4));
    case (addr)
      0: begin
        m_mode = data & 3; m_fall = (data >> 2) & 1; m_dsrc = (data >> 3) & 1;
        m_swd = (data >> 4) & 1; m_mev = (data >> 5) & 3; m_aev = (data >> 7) & 3;
      end
      1: m_cnt = data % MOD;
      2: m_aux = data % MOD;
      3: begin m_buf = data % MOD; m_pend = 1; m_tk = 0; end
      4: begin m_top = data % MOD; m_buf = m_top; m_pend = 0; end
      5: begin
        if (data & 1) m_ovf = 0;
        if (data & 2) m_unf = 0;
        if (data & 4) m_dc = 0;
      end
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int addr, int exp, string tag);
    rd_addr = addr[2:0];
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic check_outs(string tag);
    chk({tag, " count"}, int'(count_o), m_cnt);
    chk({tag, " aux"}, int'(aux_o), m_aux);
    chk({tag, " ovf"}, int'(ovf_o), int'(m_ovf));
    chk({tag, " unf"}, int'(unf_o), int'(m_unf));
    chk({tag, " dirchg"}, int'(dirchg_o), int'(m_dc));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; s0_in = 0; s1_in = 0; smp_tick = 0; wr_en = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0;
    m_cnt = 0; m_aux = 0; m_top = MOD - 1; m_buf = MOD - 1; m_tk = 0; m_pend = 0;
    m_mode = 0; m_fall = 0; m_dsrc = 0; m_swd = 0; m_mev = 1; m_aev = 3;
    m_ovf = 0; m_unf = 0; m_dc = 0; m_pdir = 0; m_s0 = 0; m_s1 = 0; m_ovs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, 'h1A0, "R1 ctrl"); rd(1, 0, "R1 cnt"); rd(2, 0, "R1 aux");
    rd(3, MOD - 1, "R1 topbuf"); rd(4, MOD - 1, "R1 top"); rd(5, 0, "R1 flags");
    check_outs("R1");

    // R2 off mode ignores inputs
    for (int i = 0; i < 6; i++) begin
      step(i[0], i[1], 1'b1);
      check_outs("R2");
    end

    // R3 / R8 external single, up then down with wraps
    wr(0, mk_ctrl(2, 0, 0, 0, 0, 0));
    wr(4, 5);
    rd(4, 5, "R11 top write");
    for (int i = 0; i < 14; i++) begin
      step(1, 0, 0); check_outs("R8 up");
      step(0, 0, 0); check_outs("R3 fall ignored");
    end
    rd(5, int'(m_ovf) | (int'(m_unf) << 1) | (int'(m_dc) << 2), "R12 flags read");
    wr(5, 7);
    check_outs("R12 clear");
    wr(0, mk_ctrl(2, 0, 0, 1, 0, 0));
    for (int i = 0; i < 14; i++) begin
      step(1, 0, 0); check_outs("R8 down");
      step(0, 0, 0);
    end
    chk("R9 dirchg after reversal", int'(dirchg_o), 1);

    // R3 falling edge and S1 as direction
    wr(0, mk_ctrl(2, 1, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 0); check_outs("R3 falling");
      step(0, 0, 0); check_outs("R3 falling");
    end
    wr(0, mk_ctrl(2, 0, 1, 0, 0, 0));
    for (int i = 0; i < 8; i++) begin
      step(1, i[1], 0); check_outs("R3 s1 dir");
      step(0, i[1], 0);
    end

    // R6 / R7 event selector sweep
    for (int ev = 0; ev < 4; ev++) begin
      for (int sw = 0; sw < 2; sw++) begin
        wr(0, mk_ctrl(2, 0, 0, sw, ev, 3 - ev));
        wr(1, 2);
        for (int k = 0; k < 3; k++) begin
          step(1, 0, 0); check_outs("R6 selector");
          step(0, 0, 0);
        end
      end
    end
    wr(0, mk_ctrl(2, 0, 0, 0, 3, 1));
    wr(2, MOD - 2);
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0); step(0, 0, 0);
    end
    check_outs("R7 aux wrap");
    chk("R7 aux value", int'(aux_o), 1);

    // R4 oversampled single input
    wr(0, mk_ctrl(1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 24; i++) begin
      step(((i / 2) % 2) == 1, 0, (i % 3) == 0);
      check_outs("R4 strobe");
    end

    // R5 quadrature: all 16 transitions
    wr(0, mk_ctrl(3, 0, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        step((i == 1) || (i == 2), i >= 2, 0); check_outs("R5 quad");
        step((j == 1) || (j == 2), j >= 2, 0); check_outs("R5 quad");
      end
    end
    step(0, 0, 0);

    // R10 limit buffer in clock-driven and strobed modes
    wr(0, mk_ctrl(2, 0, 0, 0, 0, 3));
    wr(1, 0);
    wr(3, 9);
    rd(4, m_top, "R10 top before");
    rd(3, 9, "R10 buffer");
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0); step(0, 0, 0);
      rd(4, m_top, "R10 top per pulse");
    end
    chk("R10 top after 3 pulses", int'(rd_data), 9);
    check_outs("R10");
    wr(0, mk_ctrl(0, 0, 0, 0, 0, 3));
    wr(3, 4);
    rd(4, 9, "R10 top not yet");
    step(0, 0, 0);
    rd(4, 4, "R10 top one cycle later");

    // R11 writes squash a coincident pulse
    wr(0, mk_ctrl(2, 0, 0, 0, 0, 3));
    step(0, 0, 0);
    s0_in = 1;
    wr(1, 3);
    check_outs("R11 cnt write");
    chk("R11 cnt value", int'(count_o), 3);
    rd(0, mk_ctrl(2, 0, 0, 0, 0, 3), "R11 mode kept");
    step(0, 0, 0);
    s0_in = 1;
    wr(4, 6);
    check_outs("R11 top write");
    chk("R11 cnt held", int'(count_o), 3);
    step(0, 0, 0); step(1, 0, 0);
    check_outs("R11 resumes");

    finish_run();
  end
endmodule